// File: doc/BRIEF.md
# Flash Erase Unlock Sequencer

This block guards the erase path of an on-chip flash. It sits on a byte-wide special-function-register bus and holds three registers. The control register (address 0xB2) carries a one-shot arm bit for mass erase, a security lock and a command collision flag. The page register (0xB7) holds a 7-bit page number in bits [7:1]. The erase command register (0x94) accepts a command byte.

Only two command bytes have an effect. A page erase runs when 0x55 is written. A mass erase runs when 0xAA is written, but only if the block was armed beforehand and the debug port is enabled. When a command is accepted, the block emits a one-cycle start pulse, the erase type and the latched page number. It then stays busy until the flash side reports done.

While the security lock is set, the debug port may only request erases. The lock is released only by a completed mass erase, so a secured part can be recovered only by wiping it.

Top module: `flash_erase_guard`

## Requirements
- R1: After reset, busy, erase_start, erase_mass, the arm bit, the security lock, the collision flag and the page register are all 0.
- R2: Writing 0x55 to address 0x94 while idle drives erase_start high for exactly the next cycle. In that cycle erase_mass is 0 and erase_page equals bits [7:1] last written to address 0xB7.
- R3: Writing 1 to bit 1 of address 0xB2 arms mass erase. A following write of 0xAA to 0x94 while idle and with dbg_en high starts an erase with erase_mass = 1.
- R4: A write of 0xAA to 0x94 while idle without the arm bit, or with dbg_en low, starts nothing. Any idle write of 0xAA clears the arm bit.
- R5: While idle, a write to 0x94 of any value other than 0x55 or 0xAA starts nothing.
- R6: busy rises together with erase_start. It holds until flash_done is seen while busy, and is low from the following cycle.
- R7: A write to 0x94 while busy starts nothing and sets the collision flag (bit 0 of 0xB2). Writing 1 to bit 0 of 0xB2 clears the flag.
- R8: erase_page and erase_mass stay constant while busy, even if 0xB7 is rewritten.
- R9: Writing 1 to bit 6 of 0xB2 sets the security lock, and writing 0 does not clear it. The lock clears when a mass erase completes, that is, on flash_done during a mass erase.
- R10: dbg_grant = dbg_req AND dbg_en AND (security lock clear OR dbg_is_erase).
- R11: sfr_rdata at 0xB2 reads {busy, lock, 0000, arm, collision}. At 0xB7 it reads {page, 0}. At any other address it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for sfr_addr (combinational) |
| dbg_en | input | 1 | Debug port enabled |
| dbg_req | input | 1 | Debug port operation request |
| dbg_is_erase | input | 1 | The requested debug operation is a global erase |
| dbg_grant | output | 1 | Debug operation allowed |
| flash_done | input | 1 | Flash side has finished the erase |
| erase_start | output | 1 | One-cycle erase launch pulse |
| erase_mass | output | 1 | 1 = mass erase, 0 = page erase |
| erase_page | output | 7 | Page number being erased |
| busy | output | 1 | Erase in progress |

## Verification
The completion of an erase and a new command write can land in the same cycle. In that case the done handshake and the collision logic both act at one edge. The bench provokes this by pulsing flash_done on the same cycle as a 0x55 write to 0x94. It expects busy to fall, no new erase_start, and the collision flag to read back as set. A second case completes a mass erase while the lock is set and checks that the lock is gone.

// File: rtl/fe_pkg.sv
// Package: shared addresses, command patterns and widths for the
// flash erase guard. Assumes a byte-wide register bus.
package fe_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int PAGE_W = DATA_W - 1;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'hB2;
    localparam logic [ADDR_W-1:0] PAGE_ADDR = 8'hB7;
    localparam logic [ADDR_W-1:0] CMD_ADDR  = 8'h94;

    localparam logic [DATA_W-1:0] PAT_PAGE = 8'h55;
    localparam logic [DATA_W-1:0] PAT_MASS = 8'hAA;

    // Bit positions inside the control register
    localparam int BIT_COLL = 0;
    localparam int BIT_ARM  = 1;
    localparam int BIT_LOCK = 6;
    localparam int BIT_BUSY = 7;
endpackage

// File: rtl/fe_cmd_decode.sv
// Command decoder: turns a write to the erase command register into
// launch, disarm and collision strobes. Purely combinational; assumes
// arm and busy come from registers.
module fe_cmd_decode
    import fe_pkg::*;
(
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              arm,
    input  logic              dbg_en,
    input  logic              busy,
    output logic              go_page,
    output logic              go_mass,
    output logic              disarm,
    output logic              coll
);
    logic cmd_wr;

    // Classify the command write against state and preconditions
    always_comb begin
        cmd_wr  = wr && (addr == CMD_ADDR);
        go_page = cmd_wr && !busy && (wdata == PAT_PAGE);
        disarm  = cmd_wr && !busy && (wdata == PAT_MASS);
        go_mass = disarm && arm && dbg_en;
        coll    = cmd_wr && busy;
    end
endmodule

// File: rtl/fe_regs.sv
// Register file: arm bit, security lock, collision flag and page
// register, with the combinational read mux. Assumes single-port bus.
module fe_regs
    import fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              disarm,
    input  logic              coll_set,
    input  logic              mass_done,
    input  logic              busy,
    output logic              arm,
    output logic              lock,
    output logic              coll,
    output logic [PAGE_W-1:0] page,
    output logic [DATA_W-1:0] rdata
);
    logic ctrl_wr, page_wr;
    assign ctrl_wr = wr && (addr == CTRL_ADDR);
    assign page_wr = wr && (addr == PAGE_ADDR);

    // Update control bits and page register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm  <= 1'b0;
            lock <= 1'b0;
            coll <= 1'b0;
            page <= '0;
        end else begin
            if (ctrl_wr)              arm <= wdata[BIT_ARM];
            else if (disarm)          arm <= 1'b0;
            if (ctrl_wr && wdata[BIT_LOCK]) lock <= 1'b1;
            else if (mass_done)       lock <= 1'b0;
            if (coll_set)             coll <= 1'b1;
            else if (ctrl_wr && wdata[BIT_COLL]) coll <= 1'b0;
            if (page_wr)              page <= wdata[DATA_W-1:1];
        end
    end

    // Read mux for the addressed register
    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) begin
            rdata[BIT_BUSY] = busy;
            rdata[BIT_LOCK] = lock;
            rdata[BIT_ARM]  = arm;
            rdata[BIT_COLL] = coll;
        end else if (addr == PAGE_ADDR) begin
            rdata = {page, 1'b0};
        end
    end
endmodule

// File: rtl/fe_seq.sv
// Erase sequencer: launches an erase, latches type and page, holds
// busy until the flash side reports done. Assumes go_* are one-hot.
module fe_seq
    import fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_page,
    input  logic              go_mass,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              flash_done,
    output logic              start,
    output logic              busy,
    output logic              mass,
    output logic [PAGE_W-1:0] page_out,
    output logic              mass_done
);
    // Launch, latch and complete an erase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start    <= 1'b0;
            busy     <= 1'b0;
            mass     <= 1'b0;
            page_out <= '0;
        end else begin
            start <= go_page || go_mass;
            if (go_page || go_mass) begin
                busy     <= 1'b1;
                mass     <= go_mass;
                page_out <= page_in;
            end else if (busy && flash_done) begin
                busy <= 1'b0;
            end
        end
    end

    assign mass_done = busy && flash_done && mass;
endmodule

// File: rtl/fe_dbg_gate.sv
// Debug gate: while the lock is set, only erase requests pass.
module fe_dbg_gate (
    input  logic dbg_req,
    input  logic dbg_en,
    input  logic dbg_is_erase,
    input  logic lock,
    output logic grant
);
    // Allow a debug operation per lock state
    always_comb grant = dbg_req && dbg_en && (!lock || dbg_is_erase);
endmodule

// File: rtl/flash_erase_guard.sv
// Top: flash erase unlock sequencer. Wires the decoder, register file,
// sequencer and debug gate. Assumes one bus access per cycle.
module flash_erase_guard
    import fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_wr,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic              dbg_en,
    input  logic              dbg_req,
    input  logic              dbg_is_erase,
    output logic              dbg_grant,
    input  logic              flash_done,
    output logic              erase_start,
    output logic              erase_mass,
    output logic [PAGE_W-1:0] erase_page,
    output logic              busy
);
    logic go_page, go_mass, disarm, coll_set, mass_done;
    logic arm_q, sec_q, coll_q;
    logic [PAGE_W-1:0] page_q;

    fe_cmd_decode u_dec (
        .wr(sfr_wr), .addr(sfr_addr), .wdata(sfr_wdata), .arm(arm_q),
        .dbg_en(dbg_en), .busy(busy), .go_page(go_page), .go_mass(go_mass),
        .disarm(disarm), .coll(coll_set)
    );

    fe_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(sfr_wr), .addr(sfr_addr),
        .wdata(sfr_wdata), .disarm(disarm), .coll_set(coll_set),
        .mass_done(mass_done), .busy(busy), .arm(arm_q), .lock(sec_q),
        .coll(coll_q), .page(page_q), .rdata(sfr_rdata)
    );

    fe_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go_page(go_page), .go_mass(go_mass),
        .page_in(page_q), .flash_done(flash_done), .start(erase_start),
        .busy(busy), .mass(erase_mass), .page_out(erase_page),
        .mass_done(mass_done)
    );

    fe_dbg_gate u_dbg (
        .dbg_req(dbg_req), .dbg_en(dbg_en), .dbg_is_erase(dbg_is_erase),
        .lock(sec_q), .grant(dbg_grant)
    );
endmodule

// File: rtl/fe_guard_chk.sv
// Checker: temporal properties of the erase guard, bound to the top.
module fe_guard_chk
    import fe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sfr_wr,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              dbg_en,
    input logic              dbg_req,
    input logic              dbg_is_erase,
    input logic              dbg_grant,
    input logic              flash_done,
    input logic              erase_start,
    input logic              erase_mass,
    input logic [PAGE_W-1:0] erase_page,
    input logic              busy,
    input logic              sec_q,
    input logic              coll_q
);
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    assert_mass_needs_dbg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_start && erase_mass) |-> $past(dbg_en));

    assert_busy_with_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> busy);

    assert_busy_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && flash_done) |=> !busy);

    assert_coll_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == CMD_ADDR && busy) |=> (coll_q && !erase_start));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !flash_done) |=> (busy && $stable(erase_page) && $stable(erase_mass)));

    assert_dbg_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_grant |-> (dbg_req && dbg_en && (!sec_q || dbg_is_erase)));
endmodule

bind flash_erase_guard fe_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .dbg_en(dbg_en), .dbg_req(dbg_req), .dbg_is_erase(dbg_is_erase),
    .dbg_grant(dbg_grant), .flash_done(flash_done),
    .erase_start(erase_start), .erase_mass(erase_mass),
    .erase_page(erase_page), .busy(busy), .sec_q(sec_q), .coll_q(coll_q)
);

// File: tb/sim_flash_erase_guard.sv
// Directed bench for the flash erase guard; one task per scenario.
module sim_flash_erase_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       dbg_en = 1'b0, dbg_req = 1'b0, dbg_is_erase = 1'b0;
    logic       dbg_grant;
    logic       flash_done = 1'b0;
    logic       erase_start, erase_mass, busy;
    logic [6:0] erase_page;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    flash_erase_guard u0 (
        .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .dbg_en(dbg_en),
        .dbg_req(dbg_req), .dbg_is_erase(dbg_is_erase), .dbg_grant(dbg_grant),
        .flash_done(flash_done), .erase_start(erase_start),
        .erase_mass(erase_mass), .erase_page(erase_page), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle write; returns at the negedge after the capturing edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1 d = sfr_rdata;
    endtask

    task automatic finish_erase();
        @(negedge clk); flash_done = 1'b1;
        @(negedge clk); flash_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 busy", busy, 0);
        check("R1 start", erase_start, 0);
        rd(8'hB2, d); check("R1 ctrl", d, 8'h00);
        rd(8'hB7, d); check("R1 page", d, 8'h00);
    endtask

    task automatic t_page();
        logic [7:0] d;
        wr(8'hB7, 8'h5B);                      // page 0x2D
        rd(8'hB7, d); check("R11 page rd", d, 8'h5A);
        wr(8'h94, 8'h55);
        check("R2 start", erase_start, 1);
        check("R2 type", erase_mass, 0);
        check("R2 page", erase_page, 7'h2D);
        check("R6 busy", busy, 1);
        wr(8'hB7, 8'h02);                      // rewrite during busy
        check("R2 pulse one", erase_start, 0);
        check("R8 page held", erase_page, 7'h2D);
        repeat (3) @(negedge clk);
        check("R6 busy held", busy, 1);
        rd(8'hB2, d); check("R11 busy bit", d, 8'h80);
        finish_erase();
        check("R6 released", busy, 0);
    endtask

    task automatic t_bad_patterns();
        for (int i = 0; i < 4; i++) begin
            logic [7:0] v;
            v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : (i == 2) ? 8'h54 : 8'hAB;
            wr(8'h94, v);
            check("R5 no start", erase_start, 0);
            check("R5 idle", busy, 0);
        end
    endtask

    task automatic t_mass_refused();
        logic [7:0] d;
        dbg_en = 1'b1;
        wr(8'h94, 8'hAA);                      // not armed
        check("R4 no arm", erase_start, 0);
        dbg_en = 1'b0;
        wr(8'hB2, 8'h02);
        rd(8'hB2, d); check("R11 arm bit", d, 8'h02);
        wr(8'h94, 8'hAA);                      // armed, debug off
        check("R4 no dbg", erase_start, 0);
        rd(8'hB2, d); check("R4 disarmed", d, 8'h00);
        dbg_en = 1'b1;
        wr(8'h94, 8'hAA);                      // must need re-arm
        check("R4 rearm needed", erase_start, 0);
    endtask

    task automatic t_lock_and_mass();
        logic [7:0] d;
        wr(8'hB2, 8'h40);
        rd(8'hB2, d); check("R9 lock set", d, 8'h40);
        wr(8'hB2, 8'h00);
        rd(8'hB2, d); check("R9 lock sticky", d, 8'h40);
        dbg_req = 1'b1; dbg_is_erase = 1'b0; #1;
        check("R10 blocked", dbg_grant, 0);
        dbg_is_erase = 1'b1; #1;
        check("R10 erase ok", dbg_grant, 1);
        wr(8'hB2, 8'h02);                      // arm (lock stays)
        wr(8'h94, 8'hAA);
        check("R3 start", erase_start, 1);
        check("R3 mass", erase_mass, 1);
        rd(8'hB2, d); check("R4 arm cleared", d & 8'h02, 8'h00);
        // Done and a command write in the same cycle
        @(negedge clk);
        sfr_wr = 1'b1; sfr_addr = 8'h94; sfr_wdata = 8'h55; flash_done = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0; flash_done = 1'b0;
        check("R7 no start", erase_start, 0);
        check("R6 done", busy, 0);
        rd(8'hB2, d); check("R9 R7 lock gone coll set", d, 8'h01);
        dbg_is_erase = 1'b0; #1;
        check("R10 unlocked", dbg_grant, 1);
        dbg_en = 1'b0; #1;
        check("R10 dbg off", dbg_grant, 0);
        dbg_req = 1'b0;
        wr(8'hB2, 8'h01);
        rd(8'hB2, d); check("R7 coll clear", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page();
        t_bad_patterns();
        t_mass_refused();
        t_lock_and_mass();
        done_flag = 1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule